// File: doc/BRIEF.md
# Delay-Line Arrival-Time Encoder

This block turns the snapshot of a one-period delay line into a coarse arrival time and packs it, with the discriminator levels, into one timeslice word per crossing clock. The delay line is split into `TAPS` nodes, each covering an equal fraction of the period. With 8 nodes and a 25 ns period, one bin is about 3.1 ns. When the discriminator fires, the nodes are sampled. The block reads that sample as a thermometer pattern, counts the run of ones that starts at the earliest node, and emits the bin number as a Gray code. Neighbouring bins then differ in a single bit, and the last bin wraps to the first in one bit as well.

A register stage stores the timeslice word on each crossing clock. The low- and high-threshold levels are sampled on every edge. The time field only takes a new value on an edge where the low threshold is high, and otherwise keeps the last captured time. A flag marks the first crossing of a low-threshold pulse. The block has its own synchronous reset, so the timing path can be restarted after a loop lock failure without a general reset.

Top module: `tdc_slice_encoder`

## Requirements
- R1: A high `dtm_rst` at a clock edge sets `slice` to all zeros after that edge. It also clears the low-threshold history, so a high `thr_lo` on the first edge after reset raises the edge flag. Reset takes precedence over every other input.
- R2: The bin number is the count of consecutive ones in `taps`, starting at bit 0 (the earliest node), for counts 0 to 7.
- R3: A tap vector of all ones gives bin 7 (`TAPS`-1). The count saturates.
- R4: Ones above the first 1-to-0 transition (bubbles) do not affect the bin.
- R5: The time field `slice[2:0]` carries the Gray code of the bin. The codes for bins 0 to 7 are 000, 001, 011, 010, 110, 111, 101, 100.
- R6: The time field loads only on an edge where `thr_lo` is high. On every other edge it keeps its value.
- R7: `slice[3]` and `slice[4]` show `thr_lo` and `thr_hi` as sampled at the most recent edge, on every edge.
- R8: `slice[5]` (the edge flag) is 1 exactly when `thr_lo` is high at this edge and was low at the previous edge (or the previous edge was a reset). It is 0 whenever `thr_lo` is low.
- R9: All fields appear one clock after the edge at which their inputs are sampled. The word is ordered {edge, high, low, time[2:0]} from MSB to LSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| dtm_rst | input | 1 | Synchronous reset of the timing path, active high |
| taps | input | TAPS (8) | Sampled delay-line nodes, bit 0 earliest |
| thr_lo | input | 1 | Low-threshold discriminator level |
| thr_hi | input | 1 | High-threshold discriminator level |
| slice | output | $clog2(TAPS)+3 (6) | Registered timeslice word {edge, high, low, time} |

## Verification
Three things can happen on the same edge. The first sample of a new low-threshold pulse both loads the time field and raises the edge flag. A reset can also arrive while the low threshold is high. The bench starts low-threshold pulses on cycles that carry fresh tap patterns, including bubbled and all-ones vectors. It also asserts reset for a single cycle in the middle of a held-high pulse. A behavioural model predicts every field on every clock: reset has to win that edge, and the following edge has to flag a new pulse and capture its time.

// File: rtl/tdc_slice_encoder.sv
module tdc_slice_encoder #(
  parameter int TAPS = 8,
  localparam int BW = $clog2(TAPS),
  localparam int SW = BW + 3
) (
  input  logic            clk,
  input  logic            dtm_rst,
  input  logic [TAPS-1:0] taps,
  input  logic            thr_lo,
  input  logic            thr_hi,
  output logic [SW-1:0]   slice
);

  logic [BW:0]   run_len;
  logic [BW-1:0] bin;
  logic [BW-1:0] gray;
  logic [BW-1:0] time_q;
  logic          lo_q, hi_q, edge_q;

  always_comb begin
    logic open;
    open    = 1'b1;
    run_len = '0;
    for (int i = 0; i < TAPS; i++) begin
      if (open && taps[i]) run_len = run_len + 1'b1;
      else                 open = 1'b0;
    end
  end

  assign bin  = (int'(run_len) > TAPS - 1) ? BW'(TAPS - 1) : run_len[BW-1:0];
  assign gray = bin ^ (bin >> 1);

  always_ff @(posedge clk) begin
    if (dtm_rst) begin
      time_q <= '0;
      lo_q   <= 1'b0;
      hi_q   <= 1'b0;
      edge_q <= 1'b0;
    end else begin
      lo_q   <= thr_lo;
      hi_q   <= thr_hi;
      edge_q <= thr_lo & ~lo_q;
      if (thr_lo) time_q <= gray;
    end
  end

  assign slice = {edge_q, hi_q, lo_q, time_q};

endmodule

// File: rtl/tdc_slice_encoder_chk.sv
module tdc_slice_encoder_chk #(
  parameter int TAPS = 8,
  localparam int BW = $clog2(TAPS),
  localparam int SW = BW + 3
) (
  input logic            clk,
  input logic            dtm_rst,
  input logic [TAPS-1:0] taps,
  input logic            thr_lo,
  input logic            thr_hi,
  input logic [SW-1:0]   slice
);

  AST_RESET_CLEARS: assert property (@(posedge clk) dtm_rst |=> slice == '0); // R1

  AST_TIME_HOLDS: assert property (@(posedge clk) disable iff (dtm_rst)
    !thr_lo |=> $stable(slice[BW-1:0])); // R6

  AST_LEVELS_TRACK: assert property (@(posedge clk) disable iff (dtm_rst)
    1'b1 |=> (slice[BW] == $past(thr_lo)) && (slice[BW+1] == $past(thr_hi))); // R7

  AST_NO_EDGE_WHEN_LOW: assert property (@(posedge clk) disable iff (dtm_rst)
    !thr_lo |=> !slice[BW+2]); // R8

  AST_EDGE_ON_RISE: assert property (@(posedge clk) disable iff (dtm_rst)
    thr_lo && !$past(thr_lo) && !$past(dtm_rst) |=> slice[BW+2]); // R8

  AST_EDGE_IMPLIES_LO: assert property (@(posedge clk) disable iff (dtm_rst)
    slice[BW+2] |-> slice[BW]); // R9

endmodule

bind tdc_slice_encoder tdc_slice_encoder_chk #(.TAPS(TAPS)) u_chk (
  .clk(clk), .dtm_rst(dtm_rst), .taps(taps),
  .thr_lo(thr_lo), .thr_hi(thr_hi), .slice(slice)
);

// File: tb/tdc_slice_encoder_bench.sv
module tdc_slice_encoder_bench;
  logic       clk = 1'b0;
  logic       dtm_rst = 1'b1;
  logic [7:0] taps = '0;
  logic       thr_lo = 1'b0;
  logic       thr_hi = 1'b0;
  logic [5:0] slice;

  int    n_run = 0, n_fail = 0;
  bit    started = 0, finished = 0;
  string tag = "R2 R5";

  int e_time = 0, e_lo = 0, e_hi = 0, e_edge = 0, e_rst = 1;
  int gray_of[8] = '{0, 1, 3, 2, 6, 7, 5, 4};

  always #5 clk = ~clk;

  tdc_slice_encoder u_tdc_slice_encoder (
    .clk(clk), .dtm_rst(dtm_rst), .taps(taps),
    .thr_lo(thr_lo), .thr_hi(thr_hi), .slice(slice)
  );

  function automatic int ref_bin(logic [7:0] t);
    int n = 0;
    while (n < 8 && t[n]) n++;
    return (n > 7) ? 7 : n;
  endfunction

  always @(posedge clk) begin
    started = 1;
    e_rst = dtm_rst;
    if (dtm_rst) begin
      e_time = 0; e_lo = 0; e_hi = 0; e_edge = 0;
    end else begin
      e_edge = (thr_lo && !e_lo) ? 1 : 0;
      e_lo = thr_lo;
      e_hi = thr_hi;
      if (thr_lo) e_time = gray_of[ref_bin(taps)];
    end
  end

  task automatic check(string req, string fld, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, fld, act, exp);
    end
  endtask

  // R9: every field compared one clock after its sampling edge
  always @(negedge clk) if (started && !finished) begin
    if (e_rst) begin
      check("R1", "word", int'(slice), 0);
    end else begin
      check(tag, "time", int'(slice[2:0]), e_time);
      check("R7", "lo", int'(slice[3]), e_lo);
      check("R7", "hi", int'(slice[4]), e_hi);
      check("R8", "edge", int'(slice[5]), e_edge);
    end
  end

  task automatic step(logic [7:0] t, logic lo, logic hi);
    @(negedge clk);
    taps = t; thr_lo = lo; thr_hi = hi;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    dtm_rst = 1'b0;
    tag = "R2 R5";
    for (int n = 0; n < 8; n++) step(8'((1 << n) - 1), 1'b1, n[0]);
    step(8'h00, 1'b0, 1'b0);
    for (int n = 7; n >= 0; n--) begin
      step(8'((1 << n) - 1), 1'b1, 1'b1);
      step(8'h0F, 1'b0, 1'b0);
    end
    tag = "R3";
    step(8'hFF, 1'b1, 1'b0);
    step(8'h01, 1'b1, 1'b0);
    step(8'hFF, 1'b1, 1'b1);
    tag = "R4";
    step(8'b1010_0111, 1'b1, 1'b0);
    step(8'b1111_1110, 1'b1, 1'b0);
    step(8'b0111_1011, 1'b1, 1'b1);
    step(8'b1000_0001, 1'b1, 1'b0);
    step(8'b1011_1111, 1'b1, 1'b0);
    tag = "R6";
    step(8'h3F, 1'b1, 1'b0);
    for (int k = 0; k < 6; k++) step(8'($urandom), 1'b0, k[0]);
    tag = "R1";
    step(8'h07, 1'b1, 1'b1);
    step(8'h1F, 1'b1, 1'b1);
    dtm_rst = 1'b1;
    step(8'h7F, 1'b1, 1'b0);
    dtm_rst = 1'b0;
    step(8'h03, 1'b1, 1'b0);
    step(8'h01, 1'b1, 1'b0);
    tag = "R6 R8";
    for (int k = 0; k < 3000; k++) begin
      logic [7:0] t;
      t = ((k % 3) == 0) ? 8'($urandom) : 8'((1 << ($urandom % 9)) - 1);
      dtm_rst = (($urandom % 97) == 0);
      step(t, 1'($urandom), 1'($urandom));
    end
    dtm_rst = 1'b0;
    step(8'h00, 1'b0, 1'b0);
    @(negedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      finished = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule